// File: doc/BRIEF.md
# Saturating Bus Event Counter Bank

This block holds four performance counters that a processor reaches over an APB slave port. Each counter has a 5-bit select register that picks one of twenty event strobes from the bus fabric. The twenty strobes come in pairs, one pair for each of ten downstream crossbar ports. In each pair, one strobe pulses on a contested access to that port and the other pulses on any access to that port. A counter adds one in each cycle in which its selected strobe is high. It stops at its maximum value instead of wrapping back to zero.

To clear a counter, software writes any value to that counter's address. Select codes above the last defined event pick nothing, so a counter with such a code keeps its value. That includes the reset code 0x1F. Software therefore clears a counter and then writes its select register to start a measurement. It reads the counter later to take the result.

Top module: `bus_evt_ctr_bank`

## Requirements
- R1: There are four counters of `CTR_W` bits (default 24). Counter n is read at byte offset 0x08 + 8n. Read data bits above `CTR_W-1` are zero.
- R2: In each cycle in which a counter's selected strobe is high, that counter increases by exactly one. It never changes by more than one in a cycle.
- R3: When a counter holds all ones, further selected events leave it at all ones.
- R4: A write of any value to offset 0x08 + 8n sets counter n to zero. When the clear and a selected event fall in the same cycle, the counter ends at zero.
- R5: The select register for counter n is at offset 0x0C + 8n. It is read-write and stores only `pwdata_i[4:0]`. It resets to 0x1F, and its read data bits 31:5 are zero.
- R6: Select code c counts `evt_i[c]`. Port k (0 to 9) owns two codes. Code 2k is its contested-access strobe and code 2k+1 is its all-access strobe. The ports, in order of k, are: APB peripherals, fast peripherals, SRAM5, SRAM4, SRAM3, SRAM2, SRAM1, SRAM0, main flash execute path, ROM.
- R7: Select codes 0x14 to 0x1F match no strobe. A counter with such a code holds its value.
- R8: Every APB transfer completes in its access phase with `pready_o` high and `pslverr_o` low. A read of an unmapped offset returns zero. A write to an unmapped offset changes no register.
- R9: After reset, every counter reads zero.

A write takes effect on the clock edge that ends its access phase. A read returns the register values from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always high |
| pslverr_o | output | 1 | APB error, always low |
| evt_i | input | 20 | Event strobes, bit c is select code c |

## Verification
A one-hot strobe is walked across all twenty event bits while pairs of counters watch the even and odd codes of the same port. This separates contested counting from all-access counting and catches a port index that is off by one. Long random strobe vectors under random select codes show whether unused codes count anything and whether each counter adds at most one per cycle. The strobe vector is held at all ones in two places:
- during a clear write, which shows whether the clear or the increment wins;
- over a narrow second instance, which shows whether the counter saturates or wraps.

// File: rtl/bec_pkg.sv
`timescale 1ns/1ps
package bec_pkg;
  localparam int unsigned BEC_CTR_BASE = 8;
  localparam int unsigned BEC_STRIDE   = 8;
  localparam int unsigned BEC_SEL_GAP  = 4;

  function automatic int unsigned bec_ctr_off(input int unsigned idx);
    return BEC_CTR_BASE + BEC_STRIDE * idx;
  endfunction

  function automatic int unsigned bec_sel_off(input int unsigned idx);
    return BEC_CTR_BASE + BEC_STRIDE * idx + BEC_SEL_GAP;
  endfunction
endpackage

// File: rtl/bec_apb_decode.sv
`timescale 1ns/1ps
module bec_apb_decode #(
  parameter int NUM_CTR = 4,
  parameter int ADDR_W  = 8
) (
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output logic [NUM_CTR-1:0] ctr_hit_o,
  output logic [NUM_CTR-1:0] sel_hit_o,
  output logic              wr_o,
  output logic              rd_o
);
  import bec_pkg::*;

  assign wr_o = psel_i & penable_i & pwrite_i;
  assign rd_o = psel_i & ~pwrite_i;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_dec
    assign ctr_hit_o[g] = (paddr_i == ADDR_W'(bec_ctr_off(g)));
    assign sel_hit_o[g] = (paddr_i == ADDR_W'(bec_sel_off(g)));
  end

  always_comb begin
    a_r8_one_target: assert ($countones({ctr_hit_o, sel_hit_o}) <= 1);
  end
endmodule

// File: rtl/bec_evt_sel.sv
`timescale 1ns/1ps
module bec_evt_sel #(
  parameter int NUM_EVT = 20,
  parameter int SEL_W   = 5
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int e = 0; e < NUM_EVT; e++) begin
      if (sel_i == SEL_W'(e)) hit_o = evt_i[e];
    end
  end

  // codes past the last strobe must never fire
  always_comb begin
    if (int'(sel_i) >= NUM_EVT) a_r7_no_event: assert (!hit_o);
  end
endmodule

// File: rtl/bec_sat_ctr.sv
`timescale 1ns/1ps
module bec_sat_ctr #(
  parameter int CTR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CTR_W-1:0] cnt_o
);
  localparam logic [CTR_W-1:0] CNT_MAX = '1;

  logic [CTR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + CTR_W'(1);
  end

  assign cnt_o = cnt_q;

  a_r4_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

  a_r3_hold_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);

  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CTR_W'(1)));
endmodule

// File: rtl/bus_evt_ctr_bank.sv
`timescale 1ns/1ps
module bus_evt_ctr_bank #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 24,
  parameter int SEL_W   = 5,
  parameter int NUM_EVT = 20,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic [NUM_EVT-1:0] evt_i
);
  localparam logic [SEL_W-1:0] SEL_RST = '1;

  logic [NUM_CTR-1:0] ctr_hit, sel_hit;
  logic               wr, rd;
  logic [CTR_W-1:0]   cnt   [NUM_CTR];
  logic [SEL_W-1:0]   sel_q [NUM_CTR];
  logic [NUM_CTR-1:0] inc;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wdata;

  assign unused_wdata = ^pwdata_i[DATA_W-1:SEL_W];

  bec_apb_decode #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) u_dec (
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .ctr_hit_o (ctr_hit),
    .sel_hit_o (sel_hit),
    .wr_o      (wr),
    .rd_o      (rd)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 sel_q[g] <= SEL_RST;
      else if (wr && sel_hit[g])   sel_q[g] <= pwdata_i[SEL_W-1:0];
    end

    bec_evt_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
      .sel_i (sel_q[g]),
      .evt_i (evt_i),
      .hit_o (inc[g])
    );

    bec_sat_ctr #(.CTR_W(CTR_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (wr && ctr_hit[g]),
      .inc_i  (inc[g]),
      .cnt_o  (cnt[g])
    );

    a_r5_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr && sel_hit[g]) |=> $stable(sel_q[g]));
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (ctr_hit[i]) rd_mux = rd_mux | DATA_W'(cnt[i]);
      if (sel_hit[i]) rd_mux = rd_mux | DATA_W'(sel_q[i]);
    end
  end

  assign prdata_o  = rd ? rd_mux : '0;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
endmodule

// File: tb/sim_bus_evt_ctr_bank.sv
`timescale 1ns/1ps
module sim_bus_evt_ctr_bank;
  localparam int NC = 4;
  localparam int NE = 20;
  localparam logic [31:0] MAX0 = 32'h00FF_FFFF;
  localparam logic [31:0] MAX1 = 32'h0000_00FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [NE-1:0] evt = '0;
  logic [31:0] prdata0, prdata1;
  logic        pready0, pready1, pslverr0, pslverr1;

  int checks = 0;
  int errors = 0;
  bit rand_en = 1'b0;
  logic [NE-1:0] evt_fix = '0;

  logic [31:0] m_c0 [NC];
  logic [31:0] m_c1 [NC];
  logic [4:0]  m_sel [NC];

  always #4 clk = ~clk;

  bus_evt_ctr_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata0), .pready_o(pready0), .pslverr_o(pslverr0), .evt_i(evt));

  bus_evt_ctr_bank #(.CTR_W(8)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata1), .pready_o(pready1), .pslverr_o(pslverr1), .evt_i(evt));

  function automatic logic [31:0] step(input logic [31:0] cur, input logic [31:0] mx,
                                       input logic clr, input logic hit);
    if (clr) return 32'd0;
    if (hit && cur != mx) return cur + 32'd1;
    return cur;
  endfunction

  // reference model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NC; n++) begin
        m_c0[n] <= '0; m_c1[n] <= '0; m_sel[n] <= 5'h1F;
      end
    end else begin
      for (int n = 0; n < NC; n++) begin
        logic wr_c, wr_s, hit;
        wr_c = psel && penable && pwrite && paddr == 8'(8 + 8 * n);
        wr_s = psel && penable && pwrite && paddr == 8'(12 + 8 * n);
        hit  = (int'(m_sel[n]) < NE) ? evt[m_sel[n]] : 1'b0;
        m_c0[n] <= step(m_c0[n], MAX0, wr_c, hit);
        m_c1[n] <= step(m_c1[n], MAX1, wr_c, hit);
        if (wr_s) m_sel[n] <= pwdata[4:0];
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input bit narrow);
    for (int n = 0; n < NC; n++) begin
      if (a == 8'(8 + 8 * n))  return narrow ? m_c1[n] : m_c0[n];
      if (a == 8'(12 + 8 * n)) return {27'd0, m_sel[n]};
    end
    return 32'd0;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      #1;
      evt = rand_en ? NE'($urandom) : evt_fix;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, input string tag);
    logic [31:0] e0, e1;
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #2;
    e0 = exp_rd(a, 1'b0);
    e1 = exp_rd(a, 1'b1);
    chk(tag, prdata0, e0);
    chk(tag, prdata1, e1);
    chk("R8 ready/err", {30'd0, pready0 & pready1, pslverr0 | pslverr1}, 32'd2);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_all(input string tag);
    for (int n = 0; n < NC; n++) begin
      apb_rd(8'(8 + 8 * n), tag);
      apb_rd(8'(12 + 8 * n), tag);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state, R5 reset select
    for (int n = 0; n < NC; n++) begin
      apb_rd(8'(8 + 8 * n), "R9 reset count");
      apb_rd(8'(12 + 8 * n), "R5 reset select");
    end

    // R7 reset codes count nothing under random strobes
    rand_en = 1; idle(40); rand_en = 0;
    for (int n = 0; n < NC; n++) begin
      apb_rd(8'(8 + 8 * n), "R7 dead code holds");
      chk("R7 literal", prdata0, 32'd0);
    end

    // R8 unmapped reads
    apb_rd(8'h00, "R8 unmapped");
    apb_rd(8'h04, "R8 unmapped");
    apb_rd(8'h28, "R8 unmapped");
    apb_rd(8'h0A, "R8 unmapped");

    // R5 only low bits stored
    apb_wr(8'h0C, 32'hFFFF_FFE3);
    apb_rd(8'h0C, "R5 select width");
    chk("R5 literal", prdata0, 32'h3);

    // R6 one-hot walk: ctr0 contested, ctr1 all-access of port k
    for (int k = 0; k < 10; k++) begin
      evt_fix = '0;
      apb_wr(8'h0C, 32'(2 * k));
      apb_wr(8'h14, 32'(2 * k + 1));
      apb_wr(8'h1C, 32'((2 * k + 2) % NE));
      apb_wr(8'h08, 32'h0);
      apb_wr(8'h10, 32'h0);
      apb_wr(8'h18, 32'h0);
      evt_fix = NE'(1) << (2 * k);
      idle(5);
      evt_fix = NE'(1) << (2 * k + 1);
      idle(3);
      evt_fix = '0;
      idle(1);
      apb_rd(8'h08, "R6 contested code");
      chk("R6 contested literal", prdata0, 32'd5);
      apb_rd(8'h10, "R6 all-access code");
      chk("R2 all-access literal", prdata0, 32'd3);
      apb_rd(8'h18, "R6 neighbour code");
    end

    // R4 clear wins against a simultaneous event
    apb_wr(8'h0C, 32'h1);
    evt_fix = '1; idle(5);
    apb_wr(8'h08, 32'hABCD);
    evt_fix = '0;
    idle(1);
    apb_rd(8'h08, "R4 clear wins");
    chk("R4 literal", prdata0, 32'd0);

    // R3 saturation on narrow instance, R1 wide keeps counting
    apb_wr(8'h08, 32'h0);
    evt_fix = '1; idle(300); evt_fix = '0;
    idle(1);
    apb_rd(8'h08, "R3 saturate");
    chk("R3 literal", prdata1, 32'hFF);
    chk("R1 wide above narrow max", {31'd0, prdata0 > 32'hFF}, 32'd1);

    // R2/R6/R7 random selects, strobes and clears
    for (int r = 0; r < 30; r++) begin
      for (int n = 0; n < NC; n++) begin
        apb_wr(8'(12 + 8 * n), $urandom);
        if ($urandom_range(0, 2) == 0) apb_wr(8'(8 + 8 * n), $urandom);
      end
      rand_en = 1;
      idle($urandom_range(20, 100));
      rand_en = 0;
      rd_all("R2 R6 random");
    end

    // R8 unmapped writes change nothing
    rand_en = 0; evt_fix = '0;
    apb_wr(8'h04, 32'hFFFF_FFFF);
    apb_wr(8'h28, 32'h0);
    apb_wr(8'h09, 32'h0);
    rd_all("R8 unmapped write");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule